// File: doc/BRIEF.md
# Trigger Gate with Busy Handshake

This block sits between a raw detector trigger and the front-end readout processors. It decides whether each trigger is passed on or dropped, using a single busy flag. The gate comes out of reset closed. It opens only when the host sends a release-busy strobe, which the host does once it has finished configuring the system. Each trigger that passes closes the gate again. Triggers that arrive while the gate is closed are dropped and counted.

After every trigger that passes, the block starts a settling window of a fixed number of clocks. This gives the front-end processors time to compress their event data. For the length of that window, the acknowledge of the host's command handshake is withheld, so the host's read commands stay pending. A release-busy strobe that arrives inside the window is remembered and takes effect only when the window ends.

Top module: `trig_busy_gate`

## Requirements
- R1: When `rst` is high at a clock edge, the block afterwards shows `busy` = 1, `trig_out` = 0, `veto_cnt` = 0 and no settling window in progress.
- R2: While no settling window is running, a one-cycle `rel_busy` pulse makes `busy` read 0 from the next cycle on. A `rel_busy` pulse while `busy` is already 0 has no effect. The end of a settling window never clears `busy` by itself.
- R3: A trigger edge seen while `busy` = 1 produces no `trig_out` pulse and adds one to `veto_cnt`.
- R4: A trigger edge seen while `busy` = 0 produces a `trig_out` pulse one clock wide in the cycle after the edge. `busy` reads 1 in that same cycle.
- R5: `cmd_ack` equals `cmd_stb` AND `fe_cmd_ack`, except during a settling window, when it is 0. The window covers exactly `HOLD_CYC` cycles, starting with the cycle in which `trig_out` is high.
- R6: A trigger is a 0-to-1 transition of `trig_in`. A level held high counts once and never produces a second pass or veto.
- R7: A `rel_busy` pulse during a settling window keeps `busy` at 1 until the window ends. `busy` then reads 0 in the first cycle after the window.
- R8: `veto_cnt` is `VETO_W` bits wide (16 by default) and stops at all-ones instead of wrapping.
- R9: A one-cycle `veto_clr` pulse makes `veto_cnt` read 0 in the next cycle. It takes priority over a veto counted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Raw trigger line, rising edge significant |
| rel_busy | input | 1 | Host strobe that opens the gate |
| veto_clr | input | 1 | Host strobe that zeroes the veto counter |
| cmd_stb | input | 1 | Host command strobe |
| fe_cmd_ack | input | 1 | Acknowledge returned by the front-end side |
| trig_out | output | 1 | Gated trigger pulse to all front-end boards |
| busy | output | 1 | Gate closed flag |
| veto_cnt | output | VETO_W | Number of dropped triggers, saturating |
| cmd_ack | output | 1 | Command acknowledge to the host, held during settling |

## Verification
The bench builds the block with `HOLD_CYC` = 20 and `VETO_W` = 4. The short window lets every boundary of the settling interval be checked cycle by cycle: the last held cycle, the first released cycle, and a deferred release. The narrow counter reaches its saturation point after only fifteen dropped triggers, which makes the R8 stop-at-maximum case reachable in a few hundred cycles.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic [1:0] {
        GS_LOCKED = 2'd0,
        GS_SETTLE = 2'd1,
        GS_OPEN   = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic fire;
        logic veto;
    } gate_evt_t;

    function automatic int unsigned hold_width(input int unsigned cycles);
        return (cycles < 2) ? 1 : $clog2(cycles + 1);
    endfunction

endpackage

// File: rtl/tg_edge.sv
module tg_edge (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic din_q;

    always_ff @(posedge clk) begin
        if (rst) din_q <= 1'b1;
        else     din_q <= din;
    end

    assign rise = din & ~din_q;
endmodule

// File: rtl/tg_holdoff.sv
module tg_holdoff
    import tg_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 437500
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic active,
    output logic last
);
    localparam int unsigned TW = hold_width(HOLD_CYC);
    localparam logic [TW-1:0] LOAD_VAL = TW'(HOLD_CYC);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)              remain <= '0;
        else if (load)        remain <= LOAD_VAL;
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign active = (remain != '0);
    assign last   = (remain == TW'(1));
endmodule

// File: rtl/tg_busy_fsm.sv
module tg_busy_fsm
    import tg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rise,
    input  logic      rel,
    input  logic      hold_last,
    output gate_evt_t evt,
    output logic      busy,
    output logic      fire_q
);
    gate_state_e state, state_nx;
    logic        pend, pend_nx;

    always_comb begin
        evt.fire = rise && (state == GS_OPEN);
        evt.veto = rise && (state != GS_OPEN);
    end

    always_comb begin
        state_nx = state;
        pend_nx  = pend;
        unique case (state)
            GS_LOCKED: if (rel) state_nx = GS_OPEN;
            GS_OPEN: begin
                if (rise) begin
                    state_nx = GS_SETTLE;
                    pend_nx  = 1'b0;
                end
            end
            GS_SETTLE: begin
                if (hold_last) begin
                    state_nx = (pend || rel) ? GS_OPEN : GS_LOCKED;
                    pend_nx  = 1'b0;
                end else if (rel) begin
                    pend_nx  = 1'b1;
                end
            end
            default: state_nx = GS_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= GS_LOCKED;
            pend   <= 1'b0;
            fire_q <= 1'b0;
        end else begin
            state  <= state_nx;
            pend   <= pend_nx;
            fire_q <= evt.fire;
        end
    end

    assign busy = (state != GS_OPEN);
endmodule

// File: rtl/tg_veto_cnt.sv
module tg_veto_cnt #(
    parameter int unsigned VETO_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [VETO_W-1:0] count
);
    localparam logic [VETO_W-1:0] TOP = {VETO_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)              count <= '0;
        else if (inc && count != TOP) count <= count + 1'b1;
    end
endmodule

// File: rtl/trig_busy_gate.sv
module trig_busy_gate
    import tg_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 437500,
    parameter int unsigned VETO_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_in,
    input  logic              rel_busy,
    input  logic              veto_clr,
    input  logic              cmd_stb,
    input  logic              fe_cmd_ack,
    output logic              trig_out,
    output logic              busy,
    output logic [VETO_W-1:0] veto_cnt,
    output logic              cmd_ack
);
    logic      trig_rise;
    logic      hold_active;
    logic      hold_last;
    gate_evt_t evt;

    tg_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (trig_in),
        .rise (trig_rise)
    );

    tg_busy_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rise      (trig_rise),
        .rel       (rel_busy),
        .hold_last (hold_last),
        .evt       (evt),
        .busy      (busy),
        .fire_q    (trig_out)
    );

    tg_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (evt.fire),
        .active (hold_active),
        .last   (hold_last)
    );

    tg_veto_cnt #(.VETO_W(VETO_W)) u_veto (
        .clk   (clk),
        .rst   (rst),
        .clr   (veto_clr),
        .inc   (evt.veto),
        .count (veto_cnt)
    );

    assign cmd_ack = cmd_stb & fe_cmd_ack & ~hold_active;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
    parameter int unsigned VETO_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              trig_out,
    input logic              busy,
    input logic              veto_clr,
    input logic [VETO_W-1:0] veto_cnt,
    input logic              cmd_ack,
    input logic              trig_rise,
    input logic              hold_active
);
    a_r1_busy_after_reset: assert property (@(posedge clk)
        $past(rst) |-> busy);

    a_r3_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (trig_rise && busy) |=> !trig_out);

    a_r4_fire_sets_busy: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> busy);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out);

    a_r5_ack_held: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> !cmd_ack);

    a_r7_hold_keeps_busy: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> busy);

    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(veto_cnt) == {VETO_W{1'b1}} && !$past(veto_clr))
            |-> veto_cnt == {VETO_W{1'b1}});

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(veto_clr)) |-> veto_cnt == '0);
endmodule

bind trig_busy_gate tg_checker #(.VETO_W(VETO_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .trig_out    (trig_out),
    .busy        (busy),
    .veto_clr    (veto_clr),
    .veto_cnt    (veto_cnt),
    .cmd_ack     (cmd_ack),
    .trig_rise   (trig_rise),
    .hold_active (hold_active)
);

// File: tb/test_trig_busy_gate.sv
`timescale 1ns/1ps
module test_trig_busy_gate;
    localparam int unsigned HOLD = 20;
    localparam int unsigned VW   = 4;
    localparam int unsigned VMAX = (1 << VW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_in = 1'b0;
    logic          rel_busy = 1'b0;
    logic          veto_clr = 1'b0;
    logic          cmd_stb = 1'b1;
    logic          fe_cmd_ack = 1'b1;
    logic          trig_out;
    logic          busy;
    logic [VW-1:0] veto_cnt;
    logic          cmd_ack;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    int unsigned cyc    = 0;
    int unsigned exp_veto = 0;
    int unsigned exp_q[$];
    bit          done = 1'b0;

    trig_busy_gate #(.HOLD_CYC(HOLD), .VETO_W(VW)) i_trig_busy_gate (
        .clk(clk), .rst(rst), .trig_in(trig_in), .rel_busy(rel_busy),
        .veto_clr(veto_clr), .cmd_stb(cmd_stb), .fe_cmd_ack(fe_cmd_ack),
        .trig_out(trig_out), .busy(busy), .veto_cnt(veto_cnt), .cmd_ack(cmd_ack)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic note_veto;
        if (exp_veto < VMAX) exp_veto++;
    endtask

    // Driver: one rising edge of the trigger; a pass pushes its expected cycle
    task automatic pulse_trig(input bit pass);
        trig_in = 1'b1;
        if (pass) exp_q.push_back(cyc + 1);
        else      note_veto();
        tick();
        trig_in = 1'b0;
        tick();
    endtask

    task automatic release_pulse;
        rel_busy = 1'b1;
        tick();
        rel_busy = 1'b0;
    endtask

    // Monitor: scoreboard for the gated trigger (R4)
    always @(negedge clk) begin
        if (!rst) begin
            if (trig_out) begin
                n_run++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R4: actual unexpected trig_out expected none (cycle %0d)", cyc);
                end else begin
                    int unsigned e;
                    e = exp_q.pop_front();
                    if (e != cyc) begin
                        n_fail++;
                        $display("FAIL R4: actual pulse cycle %0d expected %0d", cyc, e);
                    end
                end
            end else if (exp_q.size() != 0 && exp_q[0] < cyc) begin
                int unsigned e;
                n_run++;
                n_fail++;
                e = exp_q.pop_front();
                $display("FAIL R4: actual no pulse expected pulse at cycle %0d", e);
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 busy", busy, 1);
        chk("R1 trig_out", trig_out, 0);
        chk("R1 veto_cnt", veto_cnt, 0);
        chk("R5 ack passes with no window", cmd_ack, 1);

        // R3 trigger while busy after reset
        pulse_trig(1'b0);
        chk("R3 veto counted", veto_cnt, exp_veto);
        chk("R3 busy", busy, 1);

        // R6 held level counts once
        trig_in = 1'b1;
        note_veto();
        repeat (5) tick();
        trig_in = 1'b0;
        tick();
        chk("R6 held level one veto", veto_cnt, exp_veto);

        // R2 release opens gate; second release no effect
        release_pulse();
        chk("R2 busy cleared", busy, 0);
        release_pulse();
        tick();
        chk("R2 extra release no effect", busy, 0);

        // R4 / R5 pass and hold-off window bounds
        trig_in = 1'b1;
        exp_q.push_back(cyc + 1);
        tick();
        chk("R4 busy set on pass", busy, 1);
        chk("R5 ack held first cycle", cmd_ack, 0);
        trig_in = 1'b0;
        repeat (HOLD - 1) tick();
        chk("R5 ack held last cycle", cmd_ack, 0);
        tick();
        chk("R5 ack returns after window", cmd_ack, 1);
        chk("R2 window end keeps busy", busy, 1);
        cmd_stb = 1'b0;
        tick();
        chk("R5 ack needs strobe", cmd_ack, 0);
        cmd_stb = 1'b1;

        // R7 deferred release, with a vetoed trigger inside the window (R3)
        release_pulse();
        chk("R2 busy cleared again", busy, 0);
        trig_in = 1'b1;
        exp_q.push_back(cyc + 1);
        tick();                              // E0
        trig_in = 1'b0;
        rel_busy = 1'b1;
        tick();                              // E0+1
        rel_busy = 1'b0;
        chk("R7 busy held after early release", busy, 1);
        trig_in = 1'b1;
        note_veto();
        tick();                              // E0+2
        trig_in = 1'b0;
        chk("R3 veto in window", veto_cnt, exp_veto);
        repeat (HOLD - 3) tick();            // E0+HOLD-1
        chk("R7 busy until window end", busy, 1);
        tick();                              // E0+HOLD
        chk("R7 busy drops at window end", busy, 0);
        chk("R7 ack back at window end", cmd_ack, 1);

        // R6 level held across a full cycle of pass and release
        trig_in = 1'b1;
        exp_q.push_back(cyc + 1);
        tick();
        release_pulse();
        repeat (HOLD - 1) tick();
        repeat (3) tick();
        chk("R6 no second pass from held level", busy, 0);
        trig_in = 1'b0;
        tick();

        // R8 saturation
        pulse_trig(1'b1);
        for (int i = 0; i < 20; i++) pulse_trig(1'b0);
        chk("R8 saturated", veto_cnt, VMAX);
        pulse_trig(1'b0);
        chk("R8 stays saturated", veto_cnt, VMAX);

        // R9 clear wins over simultaneous veto
        veto_clr = 1'b1;
        trig_in  = 1'b1;
        tick();
        veto_clr = 1'b0;
        trig_in  = 1'b0;
        exp_veto = 0;
        chk("R9 clear priority", veto_cnt, 0);
        tick();
        pulse_trig(1'b0);
        chk("R9 counts after clear", veto_cnt, exp_veto);

        // R1 reset during operation
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 busy after mid reset", busy, 1);
        chk("R1 veto after mid reset", veto_cnt, 0);

        tick();
        chk("R4 all expected pulses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule